// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps a running calendar clock and exposes it to a host as a small byte-addressed register file. The host sees seconds, minutes, hours, day of week, date, month and a two-digit year, all in BCD. There is also a control byte and a stop flag that sits in the top bit of the seconds register. The clock moves forward by one second on each pulse of an external one-second tick. Carries ripple from seconds up to the year, and the month length and a divisible-by-four leap rule decide when the date wraps.

The host sets one field per write. Each write is decoded and range-checked, and a value that is out of range or not valid decimal is dropped without any error. Reads are combinational and return the live values packed in BCD. Setting the stop flag freezes the count. Clearing it resumes counting from the frozen value, so no time is lost and none is skipped.

Top module: `bcd_tod_regfile`

## Requirements
- R1: After reset the map reads control 0x00 at address 0, seconds 0x00 at 1, minutes 0x00 at 2, hours 0x00 at 3, day-of-week 0x01 at 4, date 0x01 at 5, month 0x01 at 6 and year 0x00 at 7.
- R2: Each tick with the stop flag clear adds one second. Seconds wrap 59 to 0 and carry into minutes, and minutes wrap 59 to 0 and carry into hours.
- R3: Hours wrap 23 to 0 and carry into both the date and the day of week. Day of week counts 1 to 7 and wraps to 1. The date wraps to 1 after day 31, 30, or 28/29 for February, where years divisible by four have 29 days. The month wraps 12 to 1 and carries into the year, and the year wraps 99 to 0.
- R4: Bit 7 of address 1 is the stop flag. A write to address 1 always stores it, and reads return it above the BCD seconds. While it is set, ticks change nothing.
- R5: Writes to seconds or minutes decode bits 6:0 as BCD and are kept only for 0 to 59 with both digits decimal.
- R6: Hour writes decode bits 5:0 and are kept only for 0 to 23 with decimal digits.
- R7: Date writes decode bits 5:0 and are kept only when the value is decimal and nonzero. Month writes decode bits 4:0 and are kept only for 1 to 12.
- R8: Year writes decode all eight bits and are kept only when both digits are decimal (0 to 99).
- R9: A write to address 4 stores bits 2:0 as the day of week and bit 6 as a century flag. Reads return the century flag in bit 6, the day of week in bits 2:0, and zeros elsewhere.
- R10: A write to address 0 stores the byte with bit 5 cleared and bits 7 and 4 set.
- R11: Addresses 8 to 15 read as zero, and writes to them change no register.
- R12: When a write hits a field in the same cycle as a tick, that field takes the written value. The carries of the tick still reach the other fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register byte address, shared by reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |

## Verification
On every cycle the assertions hold the stored fields inside their legal ranges. They also check that a frozen clock keeps its seconds, that seconds wrap at 59, that a write beats a tick in the same cycle, that the forced control bits are present, and that unmapped addresses read zero. Month-length and leap-year wraps, the day-of-week cycle, the year rollover and the rejection of each malformed BCD value can only be shown by the bench's scenarios. The bench compares every address after every cycle against its own calendar model.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_SEC       = 1;
  localparam int unsigned A_MIN       = 2;
  localparam int unsigned A_HR        = 3;
  localparam int unsigned A_DOW       = 4;
  localparam int unsigned A_DATE      = 5;
  localparam int unsigned A_MON       = 6;
  localparam int unsigned A_YR        = 7;
  localparam int unsigned A_FIRST_GAP = 8;

  // live clock state, binary per field
  typedef struct packed {
    logic [7:0] ctrl;
    logic       stop;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic       cent;
    logic [5:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } tod_state_t;

  // decoded, range-checked host writes
  typedef struct packed {
    logic       ctrl_ld;
    logic [7:0] ctrl_val;
    logic       stop_ld;
    logic       stop_val;
    logic       sec_ld;
    logic [5:0] sec_val;
    logic       min_ld;
    logic [5:0] min_val;
    logic       hr_ld;
    logic [4:0] hr_val;
    logic       dow_ld;
    logic [2:0] dow_val;
    logic       cent_val;
    logic       date_ld;
    logic [5:0] date_val;
    logic       mon_ld;
    logic [3:0] mon_val;
    logic       yr_ld;
    logic [6:0] yr_val;
  } tod_load_t;

  localparam tod_state_t TOD_RESET = '{
    ctrl: 8'h00, stop: 1'b0, sec: 6'd0, min: 6'd0, hr: 5'd0,
    dow: 3'd1, cent: 1'b0, date: 6'd1, mon: 4'd1, yr: 7'd0};

  function automatic logic digits_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

  function automatic logic [5:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    logic [5:0] len;
    case (mon)
      4'd2:                      len = (yr[1:0] == 2'b00) ? 6'd29 : 6'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   len = 6'd30;
      default:                   len = 6'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/tod_wr_decode.sv
module tod_wr_decode
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output tod_load_t         load_o
);

  logic [7:0] sec_raw, hr_raw, date_raw, mon_raw;
  logic [6:0] sec_bin, hr_bin, date_bin, mon_bin, yr_bin;

  always_comb begin
    sec_raw  = {1'b0, wdata_i[6:0]};
    hr_raw   = {2'b00, wdata_i[5:0]};
    date_raw = {2'b00, wdata_i[5:0]};
    mon_raw  = {3'b000, wdata_i[4:0]};
    sec_bin  = bcd_to_bin(sec_raw);
    hr_bin   = bcd_to_bin(hr_raw);
    date_bin = bcd_to_bin(date_raw);
    mon_bin  = bcd_to_bin(mon_raw);
    yr_bin   = bcd_to_bin(wdata_i);
  end

  always_comb begin
    load_o = '0;
    load_o.ctrl_val = (wdata_i & ~8'hA0) | 8'h90;
    load_o.stop_val = wdata_i[7];
    load_o.sec_val  = 6'(sec_bin);
    load_o.min_val  = 6'(sec_bin);
    load_o.hr_val   = 5'(hr_bin);
    load_o.dow_val  = wdata_i[2:0];
    load_o.cent_val = wdata_i[6];
    load_o.date_val = 6'(date_bin);
    load_o.mon_val  = 4'(mon_bin);
    load_o.yr_val   = yr_bin;
    if (wr_en_i) begin
      load_o.ctrl_ld = (addr_i == ADDR_W'(A_CTRL));
      load_o.stop_ld = (addr_i == ADDR_W'(A_SEC));
      load_o.sec_ld  = (addr_i == ADDR_W'(A_SEC)) && digits_ok(sec_raw) && (sec_bin <= 7'd59);
      load_o.min_ld  = (addr_i == ADDR_W'(A_MIN)) && digits_ok(sec_raw) && (sec_bin <= 7'd59);
      load_o.hr_ld   = (addr_i == ADDR_W'(A_HR)) && digits_ok(hr_raw) && (hr_bin <= 7'd23);
      load_o.dow_ld  = (addr_i == ADDR_W'(A_DOW));
      load_o.date_ld = (addr_i == ADDR_W'(A_DATE)) && digits_ok(date_raw) && (date_bin != 7'd0);
      load_o.mon_ld  = (addr_i == ADDR_W'(A_MON)) && digits_ok(mon_raw) &&
                       (mon_bin >= 7'd1) && (mon_bin <= 7'd12);
      load_o.yr_ld   = (addr_i == ADDR_W'(A_YR)) && digits_ok(wdata_i);
    end
  end

endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  tod_load_t  load_i,
  output tod_state_t state_o
);

  tod_state_t st_q, st_d;
  logic       adv, en;
  logic       c_sec, c_min, c_hr, c_date, c_mon;
  logic [5:0] dim;

  // next-state: tick cascade first, host loads override per field
  always_comb begin
    st_d   = st_q;
    adv    = tick_i && !st_q.stop;
    dim    = month_len(st_q.mon, st_q.yr);
    c_sec  = adv && (st_q.sec >= 6'd59);
    c_min  = c_sec && (st_q.min >= 6'd59);
    c_hr   = c_min && (st_q.hr >= 5'd23);
    c_date = c_hr && (st_q.date >= dim);
    c_mon  = c_date && (st_q.mon >= 4'd12);

    if (adv)  st_d.sec = c_sec ? 6'd0 : 6'(st_q.sec + 6'd1);
    if (c_sec) st_d.min = c_min ? 6'd0 : 6'(st_q.min + 6'd1);
    if (c_min) st_d.hr  = c_hr  ? 5'd0 : 5'(st_q.hr + 5'd1);
    if (c_hr) begin
      st_d.date = c_date ? 6'd1 : 6'(st_q.date + 6'd1);
      st_d.dow  = (st_q.dow >= 3'd7) ? 3'd1 : 3'(st_q.dow + 3'd1);
    end
    if (c_date) st_d.mon = c_mon ? 4'd1 : 4'(st_q.mon + 4'd1);
    if (c_mon)  st_d.yr  = (st_q.yr >= 7'd99) ? 7'd0 : 7'(st_q.yr + 7'd1);

    if (load_i.ctrl_ld) st_d.ctrl = load_i.ctrl_val;
    if (load_i.stop_ld) st_d.stop = load_i.stop_val;
    if (load_i.sec_ld)  st_d.sec  = load_i.sec_val;
    if (load_i.min_ld)  st_d.min  = load_i.min_val;
    if (load_i.hr_ld)   st_d.hr   = load_i.hr_val;
    if (load_i.dow_ld) begin
      st_d.dow  = load_i.dow_val;
      st_d.cent = load_i.cent_val;
    end
    if (load_i.date_ld) st_d.date = load_i.date_val;
    if (load_i.mon_ld)  st_d.mon  = load_i.mon_val;
    if (load_i.yr_ld)   st_d.yr   = load_i.yr_val;

    en = adv || load_i.ctrl_ld || load_i.stop_ld || load_i.sec_ld || load_i.min_ld ||
         load_i.hr_ld || load_i.dow_ld || load_i.date_ld || load_i.mon_ld || load_i.yr_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= TOD_RESET;
    else if (en) st_q <= st_d;
  end

  assign state_o = st_q;

  // R5: seconds and minutes stay in 0..59
  p_sec_min_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.sec <= 6'd59) && (st_q.min <= 6'd59));
  // R6: hours stay in 0..23
  p_hr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.hr <= 5'd23);
  // R7: month stays in 1..12
  p_mon_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.mon >= 4'd1) && (st_q.mon <= 4'd12));
  // R8: year stays in 0..99
  p_yr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.yr <= 7'd99);
  // R4: frozen clock keeps its seconds unless written
  p_stop_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.stop && !load_i.sec_ld |=> $stable(st_q.sec));
  // R2: seconds wrap at 59 on a live tick
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !st_q.stop && (st_q.sec == 6'd59) && !load_i.sec_ld |=> st_q.sec == 6'd0);
  // R12: a write wins over a same-cycle tick
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && load_i.sec_ld |=> st_q.sec == $past(load_i.sec_val));
  // R10: forced control bits after a control write
  p_ctrl_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i.ctrl_ld |=> st_q.ctrl[7] && st_q.ctrl[4] && !st_q.ctrl[5]);

endmodule

// File: rtl/tod_read_mux.sv
module tod_read_mux
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  tod_state_t        state_i,
  output logic [7:0]        rdata_o
);

  always_comb begin
    case (addr_i)
      ADDR_W'(A_CTRL): rdata_o = state_i.ctrl;
      ADDR_W'(A_SEC):  rdata_o = {state_i.stop, 7'(bin_to_bcd(7'(state_i.sec)))};
      ADDR_W'(A_MIN):  rdata_o = bin_to_bcd(7'(state_i.min));
      ADDR_W'(A_HR):   rdata_o = bin_to_bcd(7'(state_i.hr));
      ADDR_W'(A_DOW):  rdata_o = {1'b0, state_i.cent, 3'b000, state_i.dow};
      ADDR_W'(A_DATE): rdata_o = bin_to_bcd(7'(state_i.date));
      ADDR_W'(A_MON):  rdata_o = bin_to_bcd(7'(state_i.mon));
      ADDR_W'(A_YR):   rdata_o = bin_to_bcd(state_i.yr);
      default:         rdata_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_tod_regfile.sv
module bcd_tod_regfile
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  tod_load_t              load;
  tod_state_t             state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  tod_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .load_o  (load)
  );

  tod_time_core u_core (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_i  (tick_i),
    .load_i  (load),
    .state_o (state)
  );

  tod_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr_i  (addr_i),
    .state_i (state),
    .rdata_o (rdata_o)
  );

  // R11: unmapped addresses read zero
  p_gap_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_i >= ADDR_W'(A_FIRST_GAP)) |-> (rdata_o == 8'h00));

endmodule

// File: tb/bcd_tod_regfile_tb.sv
`timescale 1ns/100ps
module bcd_tod_regfile_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  // bench calendar model
  int m_ctrl, m_stop, m_sec, m_min, m_hr, m_dow, m_cent, m_date, m_mon, m_yr;

  bcd_tod_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic bit dec_ok(int b);
    return (((b >> 4) & 15) <= 9) && ((b & 15) <= 9);
  endfunction

  function automatic int dec(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int expect_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return (m_stop << 7) | to_bcd(m_sec);
      2: return to_bcd(m_min);
      3: return to_bcd(m_hr);
      4: return (m_cent << 6) | m_dow;
      5: return to_bcd(m_date);
      6: return to_bcd(m_mon);
      7: return to_bcd(m_yr);
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_stop = 0; m_sec = 0; m_min = 0; m_hr = 0;
    m_dow = 1; m_cent = 0; m_date = 1; m_mon = 1; m_yr = 0;
  endtask

  task automatic model_step(bit wr, int a, int d, bit tk);
    int cs, cm, ch, cd, cmo, x;
    cs = 0; cm = 0; ch = 0; cd = 0; cmo = 0;
    if (tk && m_stop == 0) begin
      // R2 R3 tick cascade from pre-edge state
      cs = (m_sec == 59); cm = cs && (m_min == 59); ch = cm && (m_hr == 23);
      cd = ch && (m_date >= mdays(m_mon, m_yr)); cmo = cd && (m_mon == 12);
      m_sec = cs ? 0 : m_sec + 1;
      if (cs) m_min = cm ? 0 : m_min + 1;
      if (cm) m_hr = ch ? 0 : m_hr + 1;
      if (ch) begin
        m_date = cd ? 1 : m_date + 1;
        m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
      end
      if (cd) m_mon = cmo ? 1 : m_mon + 1;
      if (cmo) m_yr = (m_yr == 99) ? 0 : m_yr + 1;
    end
    if (wr) begin
      case (a)
        0: m_ctrl = ((d & ~8'hA0) | 8'h90) & 8'hFF;
        1: begin
          m_stop = (d >> 7) & 1; x = d & 8'h7F;
          if (dec_ok(x) && dec(x) <= 59) m_sec = dec(x);
        end
        2: begin x = d & 8'h7F; if (dec_ok(x) && dec(x) <= 59) m_min = dec(x); end
        3: begin x = d & 8'h3F; if (dec_ok(x) && dec(x) <= 23) m_hr = dec(x); end
        4: begin m_dow = d & 7; m_cent = (d >> 6) & 1; end
        5: begin x = d & 8'h3F; if (dec_ok(x) && dec(x) != 0) m_date = dec(x); end
        6: begin x = d & 8'h1F; if (dec_ok(x) && dec(x) >= 1 && dec(x) <= 12) m_mon = dec(x); end
        7: begin if (dec_ok(d)) m_yr = dec(d); end
        default: ;
      endcase
    end
  endtask

  // read every mapped address plus two gap addresses between edges
  task automatic sweep(string tag);
    for (int i = 0; i < 10; i++) begin
      int a;
      a = (i == 8) ? 9 : (i == 9) ? 15 : i;
      addr = 4'(a);
      #0.3;
      n_chk++;
      if (int'(rdata) != expect_rd(a)) begin
        n_bad++;
        $display("FAIL %s addr %0d: got 0x%02h expected 0x%02h", tag, a, rdata, expect_rd(a));
      end
    end
  endtask

  task automatic apply(string tag, bit wr, int a, int d, bit tk);
    @(negedge clk);
    wr_en = wr; addr = 4'(a); wdata = 8'(d); tick = tk;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick = 1'b0;
    model_step(wr, a, d, tk);
    sweep(tag);
  endtask

  task automatic set_time(string tag, int yr, int mo, int dt, int hr, int mi, int se);
    apply(tag, 1, 7, yr, 0);
    apply(tag, 1, 6, mo, 0);
    apply(tag, 1, 5, dt, 0);
    apply(tag, 1, 3, hr, 0);
    apply(tag, 1, 2, mi, 0);
    apply(tag, 1, 1, se, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    sweep("R1 reset");

    // R2: seconds and minutes carry into hours
    set_time("R2 setup", 8'h23, 8'h05, 8'h10, 8'h07, 8'h59, 8'h58);
    repeat (3) apply("R2 carry", 0, 0, 0, 1);

    // R3: Feb 28 in a leap year, then in a common year
    set_time("R3 setup", 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    repeat (2) apply("R3 leap", 0, 0, 0, 1);
    set_time("R3 setup", 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    apply("R3 leap end", 0, 0, 0, 1);
    set_time("R3 setup", 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    apply("R3 common feb", 0, 0, 0, 1);
    set_time("R3 setup", 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    apply("R3 year wrap", 0, 0, 0, 1);
    set_time("R3 setup", 8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    apply("R9 dow set", 1, 4, 8'hC7, 0);
    apply("R3 dow wrap", 0, 0, 0, 1);

    // R4: stop freezes, clear resumes from frozen value
    apply("R4 stop on", 1, 1, 8'hA5, 0);
    repeat (3) apply("R4 frozen", 0, 0, 0, 1);
    apply("R4 stop off", 1, 1, 8'h25, 0);
    repeat (2) apply("R4 resume", 0, 0, 0, 1);

    // R5 R6 R7 R8: rejected values leave the field alone
    apply("R5 sec 60", 1, 1, 8'h60, 0);
    apply("R5 sec digit", 1, 1, 8'h1A, 0);
    apply("R5 min ok", 1, 2, 8'h45, 0);
    apply("R5 min 5A", 1, 2, 8'h5A, 0);
    apply("R6 hr 24", 1, 3, 8'h24, 0);
    apply("R6 hr 0F", 1, 3, 8'h0F, 0);
    apply("R6 hr ok", 1, 3, 8'hD9, 0);
    apply("R7 date 0", 1, 5, 8'h00, 0);
    apply("R7 date ok", 1, 5, 8'h17, 0);
    apply("R7 mon 13", 1, 6, 8'h13, 0);
    apply("R7 mon 0", 1, 6, 8'h00, 0);
    apply("R7 mon ok", 1, 6, 8'hE9, 0);
    apply("R8 yr A0", 1, 7, 8'hA0, 0);
    apply("R8 yr ok", 1, 7, 8'h77, 0);

    // R10: control forcing
    apply("R10 ctrl FF", 1, 0, 8'hFF, 0);
    apply("R10 ctrl 00", 1, 0, 8'h00, 0);
    apply("R10 ctrl 2C", 1, 0, 8'h2C, 0);

    // R11: gap addresses ignore writes
    apply("R11 gap wr", 1, 9, 8'h55, 0);
    apply("R11 gap wr", 1, 15, 8'hFF, 1);

    // R12: write wins over tick, carry still reaches minutes
    set_time("R12 setup", 8'h10, 8'h03, 8'h03, 8'h03, 8'h10, 8'h59);
    apply("R12 prio", 1, 1, 8'h30, 1);
    apply("R12 prio min", 1, 2, 8'h05, 1);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r, a, d;
      bit wr, tk;
      r = int'($urandom);
      wr = (r[2:0] < 3);
      tk = r[3] | r[4];
      a = r[8] ? int'(r[12:9] & 4'h7) : int'(r[12:9]);
      d = r[13] ? int'(r[23:16]) : ((r % 10) | (((r >> 4) % 6) << 4));
      if (k % 250 == 0)
        set_time("R3 random seed", 8'h24 + (k % 3), 8'h12 - (k % 2), 8'h28 + (k % 4),
                 8'h23, 8'h59, 8'h55);
      apply("R2 R3 R12 random", wr, a, d, tk);
    end

    finish_run();
  end

endmodule